// File: doc/BRIEF.md
# JTAG Scan-Chain Router with Secondary TAP Control

This block is a JTAG test access port that sits in front of a number of secondary TAPs. Its job is to decide which secondary TAPs appear on the scan chain and whether their cores are held in reset. After reset every secondary TAP is outside the chain, and the router acts as a single bypass bit between TDI and TDO.

A debug host unlocks the router by loading the link instruction and shifting in an 8-bit key word. It then loads the route instruction and shifts 32-bit words. Each word carries a write flag, a 7-bit address and a 24-bit payload. One address reaches the system control register, which can request a system reset. A range of addresses reaches one control register per secondary TAP, which sets that TAP's chain selection, wait-in-reset hold and release pulse.

Selection changes do not take effect at once. They wait until the controller has spent three TCK cycles in Run-Test/Idle. With the pass instruction loaded, the router's bypass bit feeds the selected secondary TAPs, which are chained in ascending index order. TDO is registered on the falling edge of TCK.

Top module: `jtag_tap_router`

## Requirements
- R1: An active-low `trst_n` puts the controller in Test-Logic-Reset. It deselects all secondary TAPs, clears every hold and pulse output, drops the link, and loads the pass instruction 0x3F.
- R2: The controller follows the standard 16-state JTAG TAP state machine on rising TCK edges. Five TCK cycles with TMS high reach Test-Logic-Reset from any state, and TMS low there moves to Run-Test/Idle.
- R3: The instruction register is 6 bits wide and is shifted LSB first. Capture-IR loads 6'b000001. The code 0x02 selects the 32-bit route register, and 0x07 selects the 8-bit link register. Every other code, 0x3F included, selects the pass path.
- R4: Update-DR on the link register does nothing when bit 7 is 0. When bit 7 is 1, the link is opened if bits 3:0 equal 0x9, and closed otherwise. The word 0x89 opens the link.
- R5: Update-DR on the route register writes a control register only when the link is open and bit 31 is 1. In every other case the write is ignored.
- R6: A route write to address 0x20+n (n below the TAP count) stores payload bit 8 as the pending selection of TAP n. A pending value reaches `sec_sel_o` only at the third consecutive rising edge spent in Run-Test/Idle.
- R7: In a TAP control write, payload bits 16:14 equal to 3'b001 raise `sec_hold_o[n]`. Any other value on those bits lowers it.
- R8: A TAP control write with payload bit 17 set produces a one-TCK pulse on `sec_release_o[n]` and lowers `sec_hold_o[n]`.
- R9: A route write to address 0x01 with payload bit 0 set produces a one-TCK pulse on `sysrst_req_o`. The same write with bit 0 clear produces no pulse.
- R10: Entering Test-Logic-Reset through TMS closes the link but keeps the selection and hold state.
- R11: TDO changes on falling TCK edges. With the pass path active, the router's bypass bit (captured as 0) drives `sec_tdi_o` of the lowest selected TAP. Each selected TAP feeds the next one, and the last feeds TDO. With the route register active, TDO shows only that 32-bit register (captured as 0).
- R12: Route writes to any address other than 0x01 or 0x20..0x20+NTAP-1 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Test data in |
| tdo | output | 1 | Test data out, updated on falling TCK |
| sec_tdo_i | input | NTAP | TDO of each secondary TAP |
| sec_tdi_o | output | NTAP | TDI feed to each secondary TAP |
| sec_sel_o | output | NTAP | Secondary TAP is part of the chain |
| sec_hold_o | output | NTAP | Hold secondary core in wait-in-reset |
| sec_release_o | output | NTAP | One-TCK release from wait-in-reset |
| sysrst_req_o | output | 1 | One-TCK system reset request |

## Verification
The assertions assume that `trst_n` is the only asynchronous event, and that TMS and TDI are stable around each rising TCK edge. The bench changes TMS and TDI only just after falling edges, and it samples TDO and the outputs 2 ns later. The secondary TAPs are modelled as one-bit bypass registers. Every scan starts and ends in Run-Test/Idle, so the three-cycle settling rule is exercised by cycle-exact idle counts.

// File: rtl/jtr_pkg.sv
package jtr_pkg;
  localparam int IR_W   = 6;
  localparam int DR_W   = 32;
  localparam int LINK_W = 8;
  localparam int ADDR_W = 7;

  localparam logic [IR_W-1:0] IR_ROUTE = 6'h02;
  localparam logic [IR_W-1:0] IR_LINK  = 6'h07;
  localparam logic [IR_W-1:0] IR_PASS  = 6'h3F;
  localparam logic [IR_W-1:0] IR_CAPT  = 6'b000001;

  localparam logic [3:0]        LINK_KEY = 4'h9;
  localparam logic [ADDR_W-1:0] SYS_ADDR = 7'h01;
  localparam logic [ADDR_W-1:0] TAP_BASE = 7'h20;

  localparam int WR_BIT     = 31;
  localparam int LINK_EN    = 7;
  localparam int SEL_BIT    = 8;
  localparam int RST_LO     = 14;
  localparam int REL_BIT    = 17;
  localparam int SYSRST_BIT = 0;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UP_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UP_IR
  } tap_st_e;
endpackage

// File: rtl/jtr_tap_fsm.sv
module jtr_tap_fsm
  import jtr_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e state_o
);
  tap_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RESET:  st_d = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   st_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: st_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  st_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: st_d = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  st_d = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: st_d = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  st_d = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: st_d = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  st_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: st_d = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  st_d = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: st_d = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  st_d = tms ? ST_SEL_DR : ST_IDLE;
      default:   st_d = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st_q <= ST_RESET;
    else         st_q <= st_d;

  assign state_o = st_q;

  // R2
  tlr_exit_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q == ST_RESET && !tms) |=> (st_q == ST_IDLE));

  // R2
  shift_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q == ST_SH_DR && !tms) |=> (st_q == ST_SH_DR));
endmodule

// File: rtl/jtr_ctrl_regs.sv
module jtr_ctrl_regs
  import jtr_pkg::*;
#(
  parameter int NTAP = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            in_tlr,
  input  logic            in_rti,
  input  logic            upd_link,
  input  logic            upd_route,
  input  logic [DR_W-1:0] word_i,
  output logic [NTAP-1:0] sel_o,
  output logic [NTAP-1:0] hold_o,
  output logic [NTAP-1:0] rel_o,
  output logic            sysrst_o
);
  logic              link_q;
  logic [NTAP-1:0]   pend_q, sel_q, hold_q, rel_q;
  logic              sys_q;
  logic [1:0]        rti_cnt;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;

  assign addr  = word_i[WR_BIT-1 -: ADDR_W];
  assign wr_en = upd_route && link_q && word_i[WR_BIT];

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)                        link_q <= 1'b0;
    else if (in_tlr)                    link_q <= 1'b0;
    else if (upd_link && word_i[DR_W-LINK_W+LINK_EN])
      link_q <= (word_i[DR_W-LINK_W +: 4] == LINK_KEY);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      pend_q <= '0;
      hold_q <= '0;
      rel_q  <= '0;
      sys_q  <= 1'b0;
    end else begin
      rel_q <= '0;
      sys_q <= wr_en && (addr == SYS_ADDR) && word_i[SYSRST_BIT];
      for (int i = 0; i < NTAP; i++) begin
        if (wr_en && (addr == TAP_BASE + ADDR_W'(i))) begin
          pend_q[i] <= word_i[SEL_BIT];
          if (word_i[REL_BIT]) begin
            rel_q[i]  <= 1'b1;
            hold_q[i] <= 1'b0;
          end else begin
            hold_q[i] <= (word_i[RST_LO +: 3] == 3'b001);
          end
        end
      end
    end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      rti_cnt <= '0;
      sel_q   <= '0;
    end else begin
      if (in_rti) rti_cnt <= (rti_cnt == 2'd3) ? 2'd3 : rti_cnt + 2'd1;
      else        rti_cnt <= '0;
      if (in_rti && rti_cnt >= 2'd2) sel_q <= pend_q;
    end

  assign sel_o    = sel_q;
  assign hold_o   = hold_q;
  assign rel_o    = rel_q;
  assign sysrst_o = sys_q;

  // R8
  release_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (|rel_q) |=> (rel_q == '0));

  // R9
  sysrst_pulse_chk: assert property (@(posedge tck) disable iff (!trst_n)
    sys_q |=> !sys_q);

  // R6
  sel_settle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    !$stable(sel_q) |-> $past(in_rti));

  // R5
  locked_write_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (upd_route && !link_q) |=> ($stable(pend_q) && $stable(hold_q) && !sys_q));

  // R10
  tlr_unlink_chk: assert property (@(posedge tck) disable iff (!trst_n)
    in_tlr |=> !link_q);
endmodule

// File: rtl/jtr_pass_chain.sv
module jtr_pass_chain #(
  parameter int NTAP = 4
) (
  input  logic            bp_i,
  input  logic [NTAP-1:0] sel_i,
  input  logic [NTAP-1:0] sec_tdo_i,
  output logic [NTAP-1:0] sec_tdi_o,
  output logic            out_o
);
  logic [NTAP:0] link;

  assign link[0] = bp_i;

  for (genvar g = 0; g < NTAP; g++) begin : g_stage
    assign sec_tdi_o[g] = link[g];
    assign link[g+1]    = sel_i[g] ? sec_tdo_i[g] : link[g];
  end

  assign out_o = link[NTAP];
endmodule

// File: rtl/jtag_tap_router.sv
module jtag_tap_router
  import jtr_pkg::*;
#(
  parameter int NTAP = 4
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tms,
  input  logic            tdi,
  output logic            tdo,
  input  logic [NTAP-1:0] sec_tdo_i,
  output logic [NTAP-1:0] sec_tdi_o,
  output logic [NTAP-1:0] sec_sel_o,
  output logic [NTAP-1:0] sec_hold_o,
  output logic [NTAP-1:0] sec_release_o,
  output logic            sysrst_req_o
);
  localparam int LINK_LSB = DR_W - LINK_W;

  tap_st_e         st;
  logic [IR_W-1:0] ir_sr, ir_q;
  logic [DR_W-1:0] dr_sr;
  logic            bp_q, tdo_q, chain_out;
  logic            is_route, is_link;

  jtr_tap_fsm u_fsm (
    .tck     (tck),
    .trst_n  (trst_n),
    .tms     (tms),
    .state_o (st)
  );

  assign is_route = (ir_q == IR_ROUTE);
  assign is_link  = (ir_q == IR_LINK);

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      ir_sr <= IR_CAPT;
      ir_q  <= IR_PASS;
    end else begin
      unique case (st)
        ST_RESET:  ir_q  <= IR_PASS;
        ST_CAP_IR: ir_sr <= IR_CAPT;
        ST_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
        ST_UP_IR:  ir_q  <= ir_sr;
        default: ;
      endcase
    end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      dr_sr <= '0;
      bp_q  <= 1'b0;
    end else if (st == ST_CAP_DR) begin
      dr_sr <= '0;
      bp_q  <= 1'b0;
    end else if (st == ST_SH_DR) begin
      bp_q <= tdi;
      if (is_route)     dr_sr <= {tdi, dr_sr[DR_W-1:1]};
      else if (is_link) dr_sr[DR_W-1:LINK_LSB] <= {tdi, dr_sr[DR_W-1:LINK_LSB+1]};
    end

  jtr_ctrl_regs #(.NTAP(NTAP)) u_regs (
    .tck       (tck),
    .trst_n    (trst_n),
    .in_tlr    (st == ST_RESET),
    .in_rti    (st == ST_IDLE),
    .upd_link  (st == ST_UP_DR && is_link),
    .upd_route (st == ST_UP_DR && is_route),
    .word_i    (dr_sr),
    .sel_o     (sec_sel_o),
    .hold_o    (sec_hold_o),
    .rel_o     (sec_release_o),
    .sysrst_o  (sysrst_req_o)
  );

  jtr_pass_chain #(.NTAP(NTAP)) u_chain (
    .bp_i      (bp_q),
    .sel_i     (sec_sel_o),
    .sec_tdo_i (sec_tdo_i),
    .sec_tdi_o (sec_tdi_o),
    .out_o     (chain_out)
  );

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)             tdo_q <= 1'b0;
    else if (st == ST_SH_IR) tdo_q <= ir_sr[0];
    else if (st == ST_SH_DR) tdo_q <= is_route ? dr_sr[0]
                                    : is_link ? dr_sr[LINK_LSB] : chain_out;

  assign tdo = tdo_q;

  // R1
  reset_clear_chk: assert property (@(posedge tck)
    !trst_n |-> (sec_sel_o == '0 && sec_hold_o == '0 && !sysrst_req_o));

  // R3
  ir_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == ST_UP_IR) |=> (ir_q == $past(ir_sr)));
endmodule

// File: tb/jtag_tap_router_tb_top.sv
`timescale 1ns/1ps
module jtag_tap_router_tb_top;
  localparam int NTAP = 4;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, sysrst;
  logic [NTAP-1:0] sec_tdo, sec_tdi, sel, hold, rel;
  logic [NTAP-1:0] sec_q = '0;

  always #4 tck = ~tck;
  always @(posedge tck) sec_q <= sec_tdi;
  assign sec_tdo = sec_q;

  jtag_tap_router #(.NTAP(NTAP)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .sec_tdo_i(sec_tdo), .sec_tdi_o(sec_tdi), .sec_sel_o(sel),
    .sec_hold_o(hold), .sec_release_o(rel), .sysrst_req_o(sysrst)
  );

  int n_chk = 0, n_fail = 0;
  logic [NTAP-1:0] got_rel;
  logic            got_sys;

  // {addr[6:0], payload[23:0], sel[3:0], hold[3:0], release[3:0], sysrst}
  localparam int NV = 9;
  localparam logic [43:0] VEC [NV] = '{
    {7'h21, 24'h100108, 4'b0010, 4'b0000, 4'b0000, 1'b0},
    {7'h23, 24'h104108, 4'b1010, 4'b1000, 4'b0000, 1'b0},
    {7'h23, 24'h120108, 4'b1010, 4'b0000, 4'b1000, 1'b0},
    {7'h01, 24'h000081, 4'b1010, 4'b0000, 4'b0000, 1'b1},
    {7'h01, 24'h000080, 4'b1010, 4'b0000, 4'b0000, 1'b0},
    {7'h21, 24'h000000, 4'b1000, 4'b0000, 4'b0000, 1'b0},
    {7'h24, 24'h004100, 4'b1000, 4'b0000, 4'b0000, 1'b0},
    {7'h20, 24'h00C100, 4'b1001, 4'b0000, 4'b0000, 1'b0},
    {7'h22, 24'h004000, 4'b1001, 4'b0100, 4'b0000, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    tms = m;
    tdi = d;
    #2 o = tdo;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic scan(input bit is_ir, input int n, input logic [63:0] d, output logic [63:0] q);
    logic o;
    q = '0;
    step(1'b1, 1'b0, o);
    if (is_ir) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, d[i], o);
      q[i] = o;
    end
    step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    @(negedge tck);
    #2;
    got_rel = rel;
    got_sys = sysrst;
  endtask

  task automatic load_ir(input logic [5:0] code);
    logic [63:0] q;
    scan(1'b1, 6, {58'd0, code}, q);
  endtask

  task automatic link(input logic [7:0] key);
    logic [63:0] q;
    load_ir(6'h07);
    scan(1'b0, 8, {56'd0, key}, q);
  endtask

  task automatic route(input bit wr, input logic [6:0] a, input logic [23:0] p);
    logic [63:0] q;
    load_ir(6'h02);
    scan(1'b0, 32, {32'd0, wr, a, p}, q);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] q, d;
    logic o;
    #20 trst_n = 1'b1;
    step(1'b0, 1'b0, o);
    // R1 reset state
    chk(sel == 0 && hold == 0 && rel == 0 && !sysrst, "R1", {sel, hold, rel, sysrst}, 0);

    // R1 R11: pass instruction after reset, no TAP selected -> one bit delay
    d = 64'h0000_0000_0000_00B6;
    scan(1'b0, 8, d, q);
    chk(q[0] == 1'b0 && q[7:1] == d[6:0], "R11", q[7:0], {d[6:0], 1'b0});

    // R3 capture pattern
    scan(1'b1, 6, 64'h3F, q);
    chk(q[5:0] == 6'b000001, "R3", q[5:0], 6'b000001);

    // R5 route write before link is ignored
    route(1'b1, 7'h20, 24'h000100);
    idle(4);
    chk(sel == 0, "R5", sel, 0);

    // R4 open the link, then walk the vector table (R6 R7 R8 R9 R12)
    link(8'h89);
    for (int v = 0; v < NV; v++) begin
      route(1'b1, VEC[v][43:37], VEC[v][36:13]);
      chk(got_rel == VEC[v][4:1], "R8", got_rel, VEC[v][4:1]);
      chk(got_sys == VEC[v][0], "R9", got_sys, VEC[v][0]);
      idle(4);
      chk(sel == VEC[v][12:9], "R6 R12", sel, VEC[v][12:9]);
      chk(hold == VEC[v][8:5], "R7", hold, VEC[v][8:5]);
      chk(rel == 0 && !sysrst, "R8 R9 width", {rel, sysrst}, 0);
    end

    // R5 write flag clear -> ignored
    route(1'b0, 7'h21, 24'h000100);
    idle(4);
    chk(sel == 4'b1001, "R5", sel, 4'b1001);

    // R4 wrong key closes, bit7 clear leaves closed
    link(8'h85);
    route(1'b1, 7'h21, 24'h000100);
    idle(4);
    chk(sel == 4'b1001, "R4", sel, 4'b1001);
    link(8'h09);
    route(1'b1, 7'h21, 24'h000100);
    idle(4);
    chk(sel == 4'b1001, "R4", sel, 4'b1001);
    link(8'h89);

    // R6 settle timing: new value only in the fourth RTI cycle
    route(1'b1, 7'h21, 24'h000100);
    chk(sel == 4'b1001, "R6", sel, 4'b1001);
    step(1'b0, 1'b0, o);
    step(1'b0, 1'b0, o);
    chk(sel == 4'b1001, "R6", sel, 4'b1001);
    step(1'b0, 1'b0, o);
    chk(sel == 4'b1011, "R6", sel, 4'b1011);

    // R11 pass chain through three selected TAPs (unknown code acts as pass, R3)
    load_ir(6'h15);
    d = 64'h0000_0000_0000_9C35;
    scan(1'b0, 16, d, q);
    chk(q[15:4] == d[11:0], "R11 R3", q[15:4], d[11:0]);

    // R11 route register is 32 bits, chain not included
    load_ir(6'h02);
    d = 64'h0000_0012_3456_789A;
    scan(1'b0, 40, d, q);
    chk(q[31:0] == 0 && q[39:32] == d[7:0], "R11", q[39:0], {d[7:0], 32'd0});

    // R10 TMS reset drops link, keeps selection and hold
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
    step(1'b0, 1'b0, o);
    route(1'b1, 7'h21, 24'h000000);
    idle(4);
    chk(sel == 4'b1011 && hold == 4'b0100, "R10", {sel, hold}, {4'b1011, 4'b0100});

    // R1 asynchronous reset clears everything
    trst_n = 1'b0;
    #3;
    chk(sel == 0 && hold == 0 && rel == 0 && !sysrst, "R1", {sel, hold, rel, sysrst}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule